// File: doc/BRIEF.md
# Pin Connectivity Test Controller

This block sits between a chip's functional core and its pad ring. It decides, for every pad, which value and which output enable reach the pad. In normal operation it passes the core's values and enables through unchanged. A 4-bit test-mode code from dedicated pins selects one of three board-test modes. The first floats every output so that a tester can drive the board nets. The second builds an XNOR chain from the dedicated inputs and drives the result onto the bidirectional pads. The third turns the bidirectional pads into chain inputs and drives the result onto the output-only pads.

The mode is taken once, at the first clock edge after the active-low reset is released, and it holds until the next reset. Later changes on the test pins therefore have no effect while the chip runs. The crystal-output pad has no enable and is always driven, whatever the mode. Chain input vectors arrive already packed in chain order: index 0 is the first stage. In the dedicated-input chain the stages run in this order: power-valid, bus-powered, disk-ready, drive interrupt, IORDY, DMARQ, reset pin level, drive-bus enable, drive-power-valid, system interrupt, eject.

Top module: `pin_test_ctrl`

## Requirements
- R1: While rst_ni is low, and before the first rising clock edge after it rises, every pad value and enable equals the core's functional value and enable, whatever test_mode_i is.
- R2: test_mode_i is sampled at the first rising clock edge after rst_ni rises. Later changes of test_mode_i have no effect on any pad output until the next reset.
- R3: With mode code 4'b0000 (normal), bidi_o, bidi_oe_o, out_o and out_oe_o equal bidi_func_i, bidi_func_oe_i, out_func_i and out_func_oe_i.
- R4: Codes 4'b0001 and 4'b0101 through 4'b1111 are reserved. Each behaves exactly like code 4'b0000.
- R5: With code 4'b0010 (float), every bit of bidi_oe_o and out_oe_o is 0.
- R6: In every mode, xo_o equals xo_func_i.
- R7: With code 4'b0011, every bit of bidi_oe_o is 1 and bidi_o[k] = c[k mod N_DIN]. Here c[0] = din_i[0] and c[j] = ~(c[j-1] ^ din_i[j]).
- R8: With code 4'b0011, out_o and out_oe_o equal out_func_i and out_func_oe_i.
- R9: With code 4'b0100, every bit of bidi_oe_o is 0, every bit of out_oe_o is 1, and out_o[k] = b[k mod N_BIDI]. Here b[0] = bidi_in_i[0] and b[j] = ~(b[j-1] ^ bidi_in_i[j]).
- R10: The chain outputs are combinational. A change on a chain input shows on the chain outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_mode_i | input | 4 | Test-mode code from the test pins |
| din_i | input | N_DIN | Dedicated-input pad levels, in chain order |
| bidi_in_i | input | N_BIDI | Bidirectional pad input levels, in chain order |
| bidi_func_i | input | N_BIDI | Core values for the bidirectional pads |
| bidi_func_oe_i | input | N_BIDI | Core enables for the bidirectional pads |
| out_func_i | input | N_OUT | Core values for the output-only pads |
| out_func_oe_i | input | N_OUT | Core enables for the output-only pads |
| xo_func_i | input | 1 | Crystal-output drive value |
| bidi_o | output | N_BIDI | Bidirectional pad values |
| bidi_oe_o | output | N_BIDI | Bidirectional pad enables |
| out_o | output | N_OUT | Output-only pad values |
| out_oe_o | output | N_OUT | Output-only pad enables |
| xo_o | output | 1 | Crystal-output pad value, always driven |

## Verification
The bench holds the float code during reset and checks two things: that the pads still carry the core values before the capture edge, and that moving the test pins back to normal after the capture edge does not take the design out of float mode. A design that sampled the test pins continuously would fail both checks. Every reserved code is run through a full reset. This catches a decoder that treats a reserved code as a test mode. The chains are driven with all-zero, all-one, walking-one and alternating inputs. These patterns expose a reversed stage order, XOR used in place of XNOR, and a wrap-around that repeats the wrong stage. After a reset into float mode, the crystal output is checked to make sure it still follows its source.

// File: rtl/pin_test_pkg.sv
package pin_test_pkg;

  typedef enum logic [1:0] {
    TM_NORMAL,
    TM_FLOAT,
    TM_CHAIN_DIN,
    TM_CHAIN_BIDI
  } tm_mode_e;

  localparam logic [3:0] CODE_FLOAT      = 4'b0010;
  localparam logic [3:0] CODE_CHAIN_DIN  = 4'b0011;
  localparam logic [3:0] CODE_CHAIN_BIDI = 4'b0100;

  // Unlisted and reserved codes fall back to normal.
  function automatic tm_mode_e tm_decode(input logic [3:0] code);
    case (code)
      CODE_FLOAT:      return TM_FLOAT;
      CODE_CHAIN_DIN:  return TM_CHAIN_DIN;
      CODE_CHAIN_BIDI: return TM_CHAIN_BIDI;
      default:         return TM_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/pin_test_mode_latch.sv
module pin_test_mode_latch
  import pin_test_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] test_mode_i,
  output tm_mode_e   mode_o,
  output logic       cap_o
);

  tm_mode_e mode_q;
  logic     cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TM_NORMAL;
      cap_q  <= 1'b0;
    end else if (!cap_q) begin
      mode_q <= tm_decode(test_mode_i);
      cap_q  <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign cap_o  = cap_q;

endmodule

// File: rtl/pin_xnor_chain.sv
module pin_xnor_chain #(
  parameter int unsigned N_IN  = 11,
  parameter int unsigned N_OUT = 20
) (
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o
);

  logic [N_IN-1:0] run;

  // Stage j: parity of inputs 0..j, inverted once per XNOR stage passed.
  for (genvar j = 0; j < N_IN; j++) begin : g_stage
    localparam logic [N_IN-1:0] MSK = {N_IN{1'b1}} >> (N_IN - 1 - j);
    localparam logic            INV = 1'(j % 2);
    assign run[j] = (^(in_i & MSK)) ^ INV;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_tap
    assign out_o[k] = run[k % N_IN];
  end

endmodule

// File: rtl/pin_pad_mux.sv
module pin_pad_mux
  import pin_test_pkg::*;
#(
  parameter int unsigned N_BIDI = 20,
  parameter int unsigned N_OUT  = 13
) (
  input  tm_mode_e           mode_i,
  input  logic [N_BIDI-1:0]  bidi_func_i,
  input  logic [N_BIDI-1:0]  bidi_func_oe_i,
  input  logic [N_OUT-1:0]   out_func_i,
  input  logic [N_OUT-1:0]   out_func_oe_i,
  input  logic [N_BIDI-1:0]  din_chain_i,
  input  logic [N_OUT-1:0]   bidi_chain_i,
  output logic [N_BIDI-1:0]  bidi_o,
  output logic [N_BIDI-1:0]  bidi_oe_o,
  output logic [N_OUT-1:0]   out_o,
  output logic [N_OUT-1:0]   out_oe_o
);

  always_comb begin
    bidi_o    = bidi_func_i;
    bidi_oe_o = bidi_func_oe_i;
    out_o     = out_func_i;
    out_oe_o  = out_func_oe_i;
    case (mode_i)
      TM_FLOAT: begin
        bidi_oe_o = '0;
        out_oe_o  = '0;
      end
      TM_CHAIN_DIN: begin
        bidi_o    = din_chain_i;
        bidi_oe_o = '1;
      end
      TM_CHAIN_BIDI: begin
        bidi_oe_o = '0;
        out_o     = bidi_chain_i;
        out_oe_o  = '1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pin_test_ctrl.sv
module pin_test_ctrl
  import pin_test_pkg::*;
#(
  parameter int unsigned N_DIN  = 11,
  parameter int unsigned N_BIDI = 20,
  parameter int unsigned N_OUT  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        test_mode_i,
  input  logic [N_DIN-1:0]  din_i,
  input  logic [N_BIDI-1:0] bidi_in_i,
  input  logic [N_BIDI-1:0] bidi_func_i,
  input  logic [N_BIDI-1:0] bidi_func_oe_i,
  input  logic [N_OUT-1:0]  out_func_i,
  input  logic [N_OUT-1:0]  out_func_oe_i,
  input  logic              xo_func_i,
  output logic [N_BIDI-1:0] bidi_o,
  output logic [N_BIDI-1:0] bidi_oe_o,
  output logic [N_OUT-1:0]  out_o,
  output logic [N_OUT-1:0]  out_oe_o,
  output logic              xo_o
);

  tm_mode_e          mode_q;
  logic              cap_q;
  logic [N_BIDI-1:0] din_chain;
  logic [N_OUT-1:0]  bidi_chain;

  pin_test_mode_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .test_mode_i (test_mode_i),
    .mode_o      (mode_q),
    .cap_o       (cap_q)
  );

  pin_xnor_chain #(.N_IN(N_DIN), .N_OUT(N_BIDI)) u_chain_din (
    .in_i  (din_i),
    .out_o (din_chain)
  );

  pin_xnor_chain #(.N_IN(N_BIDI), .N_OUT(N_OUT)) u_chain_bidi (
    .in_i  (bidi_in_i),
    .out_o (bidi_chain)
  );

  pin_pad_mux #(.N_BIDI(N_BIDI), .N_OUT(N_OUT)) u_mux (
    .mode_i         (mode_q),
    .bidi_func_i    (bidi_func_i),
    .bidi_func_oe_i (bidi_func_oe_i),
    .out_func_i     (out_func_i),
    .out_func_oe_i  (out_func_oe_i),
    .din_chain_i    (din_chain),
    .bidi_chain_i   (bidi_chain),
    .bidi_o         (bidi_o),
    .bidi_oe_o      (bidi_oe_o),
    .out_o          (out_o),
    .out_oe_o       (out_oe_o)
  );

  // Oscillator pad has no enable control.
  assign xo_o = xo_func_i;

endmodule

// File: rtl/pin_test_ctrl_chk.sv
module pin_test_ctrl_chk
  import pin_test_pkg::*;
#(
  parameter int unsigned N_DIN  = 11,
  parameter int unsigned N_BIDI = 20,
  parameter int unsigned N_OUT  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input tm_mode_e          mode_q,
  input logic              cap_q,
  input logic [N_DIN-1:0]  din_i,
  input logic [N_BIDI-1:0] bidi_func_oe_i,
  input logic [N_OUT-1:0]  out_func_i,
  input logic              xo_func_i,
  input logic [N_BIDI-1:0] bidi_o,
  input logic [N_BIDI-1:0] bidi_oe_o,
  input logic [N_OUT-1:0]  out_o,
  input logic [N_OUT-1:0]  out_oe_o,
  input logic              xo_o
);

  p_mode_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_q |=> $stable(mode_q));

  p_normal_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TM_NORMAL) |-> (out_o == out_func_i && bidi_oe_o == bidi_func_oe_i));

  p_float_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TM_FLOAT) |-> (bidi_oe_o == '0 && out_oe_o == '0));

  p_xo_driven_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TM_FLOAT) |-> (xo_o == xo_func_i));

  p_din_chain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TM_CHAIN_DIN) |-> (bidi_oe_o == '1 && bidi_o[0] == din_i[0]));

  p_bidi_chain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == TM_CHAIN_BIDI) |-> (bidi_oe_o == '0 && out_oe_o == '1));

endmodule

bind pin_test_ctrl pin_test_ctrl_chk #(
  .N_DIN(N_DIN), .N_BIDI(N_BIDI), .N_OUT(N_OUT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_q         (mode_q),
  .cap_q          (cap_q),
  .din_i          (din_i),
  .bidi_func_oe_i (bidi_func_oe_i),
  .out_func_i     (out_func_i),
  .xo_func_i      (xo_func_i),
  .bidi_o         (bidi_o),
  .bidi_oe_o      (bidi_oe_o),
  .out_o          (out_o),
  .out_oe_o       (out_oe_o),
  .xo_o           (xo_o)
);

// File: tb/pin_test_ctrl_tb_top.sv
module pin_test_ctrl_tb_top;

  localparam int unsigned N_DIN  = 11;
  localparam int unsigned N_BIDI = 20;
  localparam int unsigned N_OUT  = 13;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        test_mode_i = 4'b0000;
  logic [N_DIN-1:0]  din_i = '0;
  logic [N_BIDI-1:0] bidi_in_i = '0;
  logic [N_BIDI-1:0] bidi_func_i = '0;
  logic [N_BIDI-1:0] bidi_func_oe_i = '0;
  logic [N_OUT-1:0]  out_func_i = '0;
  logic [N_OUT-1:0]  out_func_oe_i = '0;
  logic              xo_func_i = 1'b0;
  logic [N_BIDI-1:0] bidi_o, bidi_oe_o;
  logic [N_OUT-1:0]  out_o, out_oe_o;
  logic              xo_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pin_test_ctrl #(.N_DIN(N_DIN), .N_BIDI(N_BIDI), .N_OUT(N_OUT)) dut_i (
    .clk_i, .rst_ni, .test_mode_i, .din_i, .bidi_in_i, .bidi_func_i,
    .bidi_func_oe_i, .out_func_i, .out_func_oe_i, .xo_func_i,
    .bidi_o, .bidi_oe_o, .out_o, .out_oe_o, .xo_o
  );

  function automatic logic [N_BIDI-1:0] exp_din_chain(input logic [N_DIN-1:0] v);
    logic [N_DIN-1:0] c;
    c[0] = v[0];
    for (int j = 1; j < N_DIN; j++) c[j] = ~(c[j-1] ^ v[j]);
    for (int k = 0; k < N_BIDI; k++) exp_din_chain[k] = c[k % N_DIN];
  endfunction

  function automatic logic [N_OUT-1:0] exp_bidi_chain(input logic [N_BIDI-1:0] v);
    logic [N_BIDI-1:0] c;
    c[0] = v[0];
    for (int j = 1; j < N_BIDI; j++) c[j] = ~(c[j-1] ^ v[j]);
    for (int k = 0; k < N_OUT; k++) exp_bidi_chain[k] = c[k % N_BIDI];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_func(input int seed);
    bidi_func_i    = N_BIDI'($urandom(seed));
    bidi_func_oe_i = N_BIDI'($urandom());
    out_func_i     = N_OUT'($urandom());
    out_func_oe_i  = N_OUT'($urandom());
    xo_func_i      = 1'($urandom());
  endtask

  task automatic chk_pass(input string req);
    chk(req, 64'(bidi_o), 64'(bidi_func_i));
    chk(req, 64'(bidi_oe_o), 64'(bidi_func_oe_i));
    chk(req, 64'(out_o), 64'(out_func_i));
    chk(req, 64'(out_oe_o), 64'(out_func_oe_i));
  endtask

  task automatic do_reset(input logic [3:0] code);
    @(negedge clk_i);
    rst_ni = 1'b0;
    test_mode_i = code;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset_capture;
    @(negedge clk_i);
    rst_ni = 1'b0;
    test_mode_i = 4'b0010;
    set_func(7);
    #1;
    chk_pass("R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk_pass("R1 before capture");
    @(posedge clk_i);
    #1;
    chk("R5", 64'({bidi_oe_o, out_oe_o}), 64'(0));
    chk("R6", 64'(xo_o), 64'(xo_func_i));
    xo_func_i = ~xo_func_i;
    #1;
    chk("R6 toggle", 64'(xo_o), 64'(xo_func_i));
    @(negedge clk_i);
    test_mode_i = 4'b0000;
    repeat (3) @(negedge clk_i);
    chk("R2 held", 64'({bidi_oe_o, out_oe_o}), 64'(0));
  endtask

  task automatic t_normal;
    do_reset(4'b0000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      set_func(100 + i);
      #1;
      chk_pass("R3");
      chk("R6 normal", 64'(xo_o), 64'(xo_func_i));
    end
    @(negedge clk_i);
    test_mode_i = 4'b0011;
    repeat (2) @(negedge clk_i);
    chk_pass("R2 normal held");
  endtask

  task automatic t_reserved;
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c == 2 || c == 3 || c == 4) continue;
      do_reset(4'(c));
      @(negedge clk_i);
      set_func(200 + c);
      #1;
      chk_pass($sformatf("R4 code %0d", c));
    end
  endtask

  task automatic t_chain_din;
    logic [N_DIN-1:0] pats [6];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = N_DIN'(1);
    pats[3] = N_DIN'(1) << (N_DIN - 1);
    pats[4] = {(N_DIN+1)/2{2'b01}};
    pats[5] = N_DIN'(1) << 6;
    do_reset(4'b0011);
    foreach (pats[i]) begin
      @(negedge clk_i);
      din_i = pats[i];
      set_func(300 + i);
      #1;
      chk("R7 value", 64'(bidi_o), 64'(exp_din_chain(pats[i])));
      chk("R7 oe", 64'(bidi_oe_o), 64'({N_BIDI{1'b1}}));
      chk("R8 out", 64'(out_o), 64'(out_func_i));
      chk("R8 oe", 64'(out_oe_o), 64'(out_func_oe_i));
    end
    @(posedge clk_i);
    #2;
    din_i = N_DIN'(3);
    #1;
    chk("R10 din", 64'(bidi_o), 64'(exp_din_chain(N_DIN'(3))));
  endtask

  task automatic t_chain_bidi;
    logic [N_BIDI-1:0] pats [5];
    pats[0] = '0;
    pats[1] = '1;
    pats[2] = N_BIDI'(1);
    pats[3] = N_BIDI'(1) << (N_BIDI - 1);
    pats[4] = {N_BIDI/2{2'b10}};
    do_reset(4'b0100);
    foreach (pats[i]) begin
      @(negedge clk_i);
      bidi_in_i = pats[i];
      set_func(400 + i);
      #1;
      chk("R9 value", 64'(out_o), 64'(exp_bidi_chain(pats[i])));
      chk("R9 out oe", 64'(out_oe_o), 64'({N_OUT{1'b1}}));
      chk("R9 bidi oe", 64'(bidi_oe_o), 64'(0));
    end
    @(posedge clk_i);
    #2;
    bidi_in_i = N_BIDI'(5) << 8;
    #1;
    chk("R10 bidi", 64'(out_o), 64'(exp_bidi_chain(N_BIDI'(5) << 8)));
  endtask

  initial begin
    t_reset_capture();
    t_normal();
    t_reserved();
    t_chain_din();
    t_chain_bidi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule